// File: doc/BRIEF.md
# Rotary Encoder Velocity Filter

This block turns the two raw pins of a worn, bouncy mechanical quadrature knob into a clean stream of signed position updates at a slow user-interface rate. Both pins are brought into the system clock domain and decoded on every clock by a Gray-code tracker. Illegal jumps and short back-and-forth chatter are filtered out before any motion is reported.

Legal transitions move a small signed counter. One whole detent's worth of transitions in the same direction produces one signed step, and the counter then recenters. These steps are summed over each audio-rate tick, and the audio sums are summed over each user-interface tick. At every user-interface tick the total (the velocity) goes through a quadratic gain and a magnitude limit. The shaped value is presented with a one-cycle strobe. Fast spins therefore move further per detent, while the limit keeps a garbled fast spin from showing up as a large jump the wrong way.

Top module: `rotary_vel_filter`

## Requirements
- R1: While reset is low, step_out is 0 and step_vld is 0.
- R2: The pin code is {enc_a, enc_b}. The sequence 00, 01, 11, 10, 00 counts as forward (+1 per transition), and the reverse sequence counts as backward (-1 per transition).
- R3: A sample in which both pins change at once is ignored and does not move the count.
- R4: A signed step is produced only when the transition count reaches +HYST or -HYST (default 4, one detent), after which the count recenters to 0. Motion that returns inside the band produces nothing. Partial motion carries over into later update windows.
- R5: Every step produced between two strobes is included in the velocity v reported at the second strobe, regardless of where the audio tick boundaries fall.
- R6: step_vld is high for exactly one cycle every AUD_DIV*UI_DIV cycles, and step_out changes only in a cycle where step_vld is high.
- R7: step_out has magnitude (GAIN_LIN*|v| + GAIN_QUAD*|v|*|v|) >> FRAC and the sign of v. With the defaults (4, 1, 2), v = 1, 2, 3, 4 give 1, 3, 5, 8.
- R8: The magnitude of step_out never exceeds LIMIT (default 20). For example, v = 8 gives +20 and v = -8 gives -20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the pin sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_a | input | 1 | Quadrature pin, high bit of the Gray code (asynchronous) |
| enc_b | input | 1 | Quadrature pin, low bit of the Gray code (asynchronous) |
| step_out | output | OW | Signed, shaped and limited step count for the last window |
| step_vld | output | 1 | One-cycle strobe marking a new step_out |

## Verification
The assertions take for granted that each pin level is held long enough to pass the two-flop synchronizer before the next change, and that the pins rest at code 00 when reset is released. The stimulus holds every code for three clocks and starts from 00. It also keeps every burst of motion inside one update window: each burst begins right after a strobe and ends well before the next one, so the expected value of each window is known exactly. Illegal jumps are driven as single-sample changes of both pins, and they are always driven in pairs so that the bench's idea of the pin position stays aligned with the real pins.

// File: rtl/enc_pkg.sv
// Shared types and helpers for the rotary encoder velocity filter.
// Assumes the forward Gray order 00 -> 01 -> 11 -> 10 -> 00 on {a, b}.
package enc_pkg;

    // One decoded pin transition: valid marks a legal move, up its direction.
    typedef struct packed {
        logic valid;
        logic up;
    } enc_step_t;

    // Forward successor of a Gray code in the encoder sequence.
    function automatic logic [1:0] gray_fwd(input logic [1:0] code);
        case (code)
            2'b00:   gray_fwd = 2'b01;
            2'b01:   gray_fwd = 2'b11;
            2'b11:   gray_fwd = 2'b10;
            default: gray_fwd = 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/enc_gray_decoder.sv
// Synchronizes the two encoder pins and decodes single-bit Gray moves.
// Assumes each pin level is stable for at least two clocks and that the
// pins rest at 00 when reset is released.
// A change of both bits in one sample is dropped.
module enc_gray_decoder
    import enc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_a,
    input  logic      pin_b,
    output enc_step_t step
);

    logic [1:0] meta_q;
    logic [1:0] sync_q;
    logic [1:0] prev_q;
    logic [2:0] fill_q;
    logic [1:0] moved;
    logic       legal;

    // Which pin bits changed since the previous sample.
    assign moved = sync_q ^ prev_q;
    // A legal move changes exactly one bit, once the pipe holds real samples.
    assign legal = fill_q[2] && (moved == 2'b01 || moved == 2'b10);

    // Two-flop synchronizer, previous-sample register and fill tracker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 2'b00;
            sync_q <= 2'b00;
            prev_q <= 2'b00;
            fill_q <= 3'b000;
        end else begin
            meta_q <= {pin_a, pin_b};
            sync_q <= meta_q;
            prev_q <= sync_q;
            fill_q <= {fill_q[1:0], 1'b1};
        end
    end

    // Register one decoded step per legal transition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= '0;
        end else begin
            step.valid <= legal;
            step.up    <= (gray_fwd(prev_q) == sync_q);
        end
    end

    // A double-bit change in one sample never yields a step (R3).
    assert_no_double_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q[2] && moved == 2'b11) |=> !step.valid);

endmodule

// File: rtl/enc_hyst_counter.sv
// Signed transition counter with a symmetric hysteresis band.
// Emits one signed detent step when the count reaches +/-HYST and then
// recenters. Motion that stays inside the band emits nothing.
module enc_hyst_counter
    import enc_pkg::*;
#(
    parameter int HYST = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  enc_step_t step,
    output logic      det_valid,
    output logic      det_up
);

    localparam int CW = $clog2(HYST) + 2;
    localparam logic signed [CW-1:0] HI  = CW'(HYST);
    localparam logic signed [CW-1:0] LO  = -HI;
    localparam logic signed [CW-1:0] ONE = CW'(1);

    logic signed [CW-1:0] cnt_q;
    logic signed [CW-1:0] cnt_nxt;

    // Candidate count after the current transition.
    assign cnt_nxt = step.up ? cnt_q + ONE : cnt_q - ONE;

    // Move the count, and recenter and emit when a band edge is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            det_valid <= 1'b0;
            det_up    <= 1'b0;
        end else if (step.valid) begin
            if (cnt_nxt == HI || cnt_nxt == LO) begin
                cnt_q     <= '0;
                det_valid <= 1'b1;
                det_up    <= step.up;
            end else begin
                cnt_q     <= cnt_nxt;
                det_valid <= 1'b0;
            end
        end else begin
            det_valid <= 1'b0;
        end
    end

    // The count always stays strictly inside the band (R4).
    assert_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q < HI) && (cnt_q > LO));

    // A detent step is only ever produced by an incoming transition (R4).
    assert_emit_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        det_valid |-> $past(step.valid));

endmodule

// File: rtl/enc_rate_accum.sv
// Clock-enable dividers for the audio and UI ticks, plus the two-level
// accumulate-and-subsample chain. vel is the net detent count of the
// UI window that ends in the cycle where ui_tick is high.
// Assumes AUD_DIV >= 2 and UI_DIV >= 1.
module enc_rate_accum #(
    parameter int AUD_DIV = 4167,
    parameter int UI_DIV  = 3429,
    parameter int VW      = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 det_valid,
    input  logic                 det_up,
    output logic                 ui_tick,
    output logic signed [VW-1:0] vel
);

    localparam int ACW = (AUD_DIV > 1) ? $clog2(AUD_DIV) : 1;
    localparam int UCW = (UI_DIV > 1) ? $clog2(UI_DIV) : 1;
    localparam logic signed [VW-1:0] ONE = VW'(1);

    logic [ACW-1:0]       aud_cnt_q;
    logic [UCW-1:0]       ui_cnt_q;
    logic                 aud_tick;
    logic signed [VW-1:0] delta;
    logic signed [VW-1:0] aud_acc_q;
    logic signed [VW-1:0] ui_acc_q;
    logic signed [VW-1:0] aud_sum;

    // Tick decode from the divider counters.
    assign aud_tick = (aud_cnt_q == ACW'(AUD_DIV - 1));
    assign ui_tick  = aud_tick && (ui_cnt_q == UCW'(UI_DIV - 1));

    // Signed contribution of this cycle's detent step.
    assign delta   = det_valid ? (det_up ? ONE : -ONE) : '0;
    // Running sums that include this cycle, so no step is dropped at a tick.
    assign aud_sum = aud_acc_q + delta;
    assign vel     = ui_acc_q + aud_sum;

    // Audio divider counts clocks and UI divider counts audio ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aud_cnt_q <= '0;
            ui_cnt_q  <= '0;
        end else if (aud_tick) begin
            aud_cnt_q <= '0;
            ui_cnt_q  <= (ui_cnt_q == UCW'(UI_DIV - 1)) ? '0 : ui_cnt_q + UCW'(1);
        end else begin
            aud_cnt_q <= aud_cnt_q + ACW'(1);
        end
    end

    // Accumulate steps per audio tick, then audio sums per UI tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aud_acc_q <= '0;
            ui_acc_q  <= '0;
        end else if (aud_tick) begin
            aud_acc_q <= '0;
            ui_acc_q  <= ui_tick ? '0 : vel;
        end else begin
            aud_acc_q <= aud_sum;
        end
    end

    // The UI tick never fires on two consecutive clocks (R6).
    assert_tick_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ui_tick |=> !ui_tick);

endmodule

// File: rtl/enc_vel_shaper.sv
// Applies the quadratic velocity gain (GAIN_LIN*|v| + GAIN_QUAD*v^2) >> FRAC,
// clamps the magnitude to LIMIT, restores the sign and registers the
// result with a one-cycle strobe. Assumes LIMIT < 2**(OW-1).
module enc_vel_shaper #(
    parameter int VW        = 12,
    parameter int OW        = 8,
    parameter int GAIN_LIN  = 4,
    parameter int GAIN_QUAD = 1,
    parameter int FRAC      = 2,
    parameter int LIMIT     = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ui_tick,
    input  logic signed [VW-1:0] vel,
    output logic signed [OW-1:0] step_out,
    output logic                 step_vld
);

    localparam int PW = 2 * VW + 16;
    localparam logic signed [OW-1:0] LIM_S = OW'(LIMIT);

    logic [VW-1:0]        mag;
    logic [PW-1:0]        poly;
    logic [PW-1:0]        scaled;
    logic [PW-1:0]        lim_mag;
    logic signed [OW-1:0] shaped;

    // Magnitude, polynomial, fixed-point scaling, clamp and re-signing.
    always_comb begin
        mag     = vel[VW-1] ? VW'(-vel) : VW'(vel);
        poly    = PW'(GAIN_LIN) * PW'(mag) + PW'(GAIN_QUAD) * PW'(mag) * PW'(mag);
        scaled  = poly >> FRAC;
        lim_mag = (scaled > PW'(LIMIT)) ? PW'(LIMIT) : scaled;
        shaped  = vel[VW-1] ? -OW'(lim_mag) : OW'(lim_mag);
    end

    // Output register, loaded only on a UI tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_out <= '0;
            step_vld <= 1'b0;
        end else begin
            step_vld <= ui_tick;
            if (ui_tick) begin
                step_out <= shaped;
            end
        end
    end

    // The output magnitude never exceeds the limit (R8).
    assert_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_out <= LIM_S) && (step_out >= -LIM_S));

    // A nonzero output carries the sign of the window velocity (R7).
    assert_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_vld && step_out != '0) |-> (step_out[OW-1] == $past(vel[VW-1])));

    // The strobe lasts a single cycle (R6).
    assert_vld_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step_vld |=> !step_vld);

    // The output holds its value between strobes (R6).
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !step_vld |-> $stable(step_out));

endmodule

// File: rtl/rotary_vel_filter.sv
// Top level: encoder pins -> Gray decoder -> hysteresis counter ->
// audio/UI accumulate chain -> velocity shaper -> strobed signed step.
// Assumes asynchronous pins with levels held for at least two clocks.
module rotary_vel_filter
    import enc_pkg::*;
#(
    parameter int HYST      = 4,
    parameter int AUD_DIV   = 4167,
    parameter int UI_DIV    = 3429,
    parameter int VW        = 12,
    parameter int OW        = 8,
    parameter int GAIN_LIN  = 4,
    parameter int GAIN_QUAD = 1,
    parameter int FRAC      = 2,
    parameter int LIMIT     = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enc_a,
    input  logic                 enc_b,
    output logic signed [OW-1:0] step_out,
    output logic                 step_vld
);

    enc_step_t            step;
    logic                 det_valid;
    logic                 det_up;
    logic                 ui_tick;
    logic signed [VW-1:0] vel;

    enc_gray_decoder u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_a (enc_a),
        .pin_b (enc_b),
        .step  (step)
    );

    enc_hyst_counter #(.HYST(HYST)) u_hyst (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .det_valid (det_valid),
        .det_up    (det_up)
    );

    enc_rate_accum #(.AUD_DIV(AUD_DIV), .UI_DIV(UI_DIV), .VW(VW)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .det_valid (det_valid),
        .det_up    (det_up),
        .ui_tick   (ui_tick),
        .vel       (vel)
    );

    enc_vel_shaper #(
        .VW(VW), .OW(OW), .GAIN_LIN(GAIN_LIN), .GAIN_QUAD(GAIN_QUAD),
        .FRAC(FRAC), .LIMIT(LIMIT)
    ) u_shape (
        .clk      (clk),
        .rst_n    (rst_n),
        .ui_tick  (ui_tick),
        .vel      (vel),
        .step_out (step_out),
        .step_vld (step_vld)
    );

endmodule

// File: tb/rotary_vel_filter_tb.sv
`timescale 1ns/1ps
// Directed bench: each task drives one scenario inside a single UI window
// and checks the strobed result against values derived from the requirements.
module rotary_vel_filter_tb;

    localparam int AUD   = 8;
    localparam int UID   = 16;
    localparam int PER   = AUD * UID;
    localparam int HOLD  = 3;
    localparam int OW    = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 enc_a = 1'b0;
    logic                 enc_b = 1'b0;
    logic signed [OW-1:0] step_out;
    logic                 step_vld;

    int total = 0;
    int bad   = 0;
    int pos   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    rotary_vel_filter #(.AUD_DIV(AUD), .UI_DIV(UID), .OW(OW)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .enc_a    (enc_a),
        .enc_b    (enc_b),
        .step_out (step_out),
        .step_vld (step_vld)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Put the pins at the Gray code for the current position.
    task automatic put_pins();
        logic [1:0] c;
        case (pos & 3)
            0: c = 2'b00;
            1: c = 2'b01;
            2: c = 2'b11;
            default: c = 2'b10;
        endcase
        @(negedge clk);
        {enc_a, enc_b} = c;
        repeat (HOLD - 1) @(negedge clk);
    endtask

    // Signed number of legal single-bit transitions.
    task automatic move(input int n);
        for (int i = 0; i < (n < 0 ? -n : n); i++) begin
            pos = pos + (n < 0 ? -1 : 1);
            put_pins();
        end
    endtask

    // Both pins flip in one sample (two Gray positions at once).
    task automatic jump();
        pos = pos + 2;
        put_pins();
    endtask

    // Wait for the next strobe and return the cycles waited.
    task automatic wait_vld(output int waited);
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!step_vld && waited < 4 * PER);
    endtask

    task automatic expect_window(input string req, input int exp);
        int w;
        wait_vld(w);
        check(req, int'(step_out), exp);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 step_out in reset", int'(step_out), 0);
        check("R1 step_vld in reset", int'(step_vld), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_timing();
        int w;
        wait_vld(w);
        check("R6 idle window value", int'(step_out), 0);
        @(negedge clk);
        check("R6 strobe one cycle", int'(step_vld), 0);
        wait_vld(w);
        check("R6 strobe period", w + 1, PER);
    endtask

    task automatic t_gain();
        move(4);   expect_window("R2 R7 one detent forward", 1);
        move(8);   expect_window("R7 two detents", 3);
        move(12);  expect_window("R5 R7 three detents across audio ticks", 5);
        move(16);  expect_window("R7 four detents", 8);
        move(-8);  expect_window("R2 R7 two detents backward", -3);
    endtask

    task automatic t_limit();
        move(32);  expect_window("R8 fast forward clamp", 20);
        move(-32); expect_window("R8 fast backward clamp", -20);
    endtask

    task automatic t_illegal();
        for (int i = 0; i < 6; i++) jump();
        expect_window("R3 double-bit jumps ignored", 0);
        move(4);   expect_window("R3 count untouched after jumps", 1);
    endtask

    task automatic t_band();
        move(3); move(-3);
        expect_window("R4 return inside band", 0);
        for (int i = 0; i < 5; i++) begin move(1); move(-1); end
        expect_window("R4 chatter suppressed", 0);
        move(2);   expect_window("R4 partial detent silent", 0);
        move(2);   expect_window("R4 partial motion carried", 1);
    endtask

    initial begin
        int w;
        t_reset();
        t_timing();
        t_gain();
        t_limit();
        t_illegal();
        t_band();
        wait_vld(w);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule